// File: doc/BRIEF.md
# MDIO Station Management Frame Master

This block is the management-side controller for a two-wire PHY management bus. It receives one register access request at a time and turns it into a complete serial frame. It derives the management clock from the system clock through a programmable half-period divider. It drives the data line while the master owns the bus and releases the line whenever the PHY is expected to answer. Both the short (single-frame) register format and the extended (indirect, two-step) format are supported.

A host presents a clause select, a two-bit opcode, a five-bit port/PHY address, a five-bit register or device address and sixteen bits of write data, and raises `req_valid` for one cycle. The controller raises `busy` at once. It sends the frame and, for read opcodes, shifts in the PHY's answer. On completion it pulses `done` and presents any read result on `rdata`. A read that returns all ones sets `no_resp`, which means no PHY answered. The bidirectional pad is split into `mdio_out`, `mdio_oe` and `mdio_in`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc`, `mdio_oe`, `no_resp` are 0 and `rdata` is 0.
- R2: Each frame is 64 bits, each sent most significant bit first, in this order: 32 ones, then a 2-bit start code, opcode, PHY/port address (5 bits), register/device address (5 bits), 2 turnaround bits, and 16 data bits. The start code is 01 when `req_ext`=0 and 00 when `req_ext`=1.
- R3: Short-format opcodes are 01 (write) and 10 (read). Extended-format opcodes are 00 (address), 01 (write), 11 (read) and 10 (read with post-increment). The opcode is sent unchanged. A frame counts as a read when (`req_ext`=0, op=10) or (`req_ext`=1, op[1]=1).
- R4: On non-read frames, the master drives all 64 bits. The turnaround is 1 then 0, and the data field carries `req_wdata`.
- R5: On read frames, `mdio_oe` is 0 for the two turnaround bits and all 16 data bits (frame bits 46..63).
- R6: Read data is sampled on `mdio_in` in the last system cycle of each MDC high phase, first bit as MSB. The result appears on `rdata` in the cycle `done` is high and holds until the next read completes.
- R7: Each frame bit lasts 2*`HALF_DIV` system cycles: MDC is low for the first `HALF_DIV` cycles and high for the rest. `mdio_out`/`mdio_oe` change only in the cycle MDC falls, or at frame start. MDC is low when idle. Elaboration fails if `HALF_DIV` does not fit the divider width, or if the MDC rate would exceed 2.5 MHz.
- R8: `busy` is high from the cycle after a request is accepted until the last data bit ends. `done` is a one-cycle pulse in the first cycle with `busy` low.
- R9: A request raised while `busy` is high is ignored and leaves the frame in flight unchanged.
- R10: `no_resp` is updated with every `done`. It is 1 for a read whose 16 data bits were all ones, and 0 otherwise.
- R11: Between frames `mdio_oe` is 0 (line undriven).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ext | input | 1 | 1 = extended format, 0 = short format |
| req_op | input | 2 | Opcode |
| req_phy | input | 5 | PHY / port address |
| req_reg | input | 5 | Register address (short) or device address (extended) |
| req_wdata | input | 16 | Data field for non-read frames |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| no_resp | output | 1 | Last completed frame was a read returning all ones |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line as seen at the pad |

## Verification
A wrong bit counter or shift register shows at the ports within one MDC period. Either `mdio_out` departs from the expected field bit, or `mdio_oe` releases or grabs the line at the wrong frame position. A divider fault moves an MDC edge and shows in the very next cycle. A fault in the capture path shows only at the `done` of a read, as a wrong `rdata` word or a wrong `no_resp`. For that reason, reads are run with distinct answer patterns and with an absent PHY.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   localparam int AD_BITS    = 5;
   localparam int DATA_BITS  = 16;
   localparam int TA_START   = FRAME_BITS - DATA_BITS - 2;
   localparam int DATA_START = FRAME_BITS - DATA_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   typedef struct packed {
      logic                 ext;
      logic [1:0]           op;
      logic [AD_BITS-1:0]   phy;
      logic [AD_BITS-1:0]   rad;
      logic [DATA_BITS-1:0] wdata;
   } mgmt_req_t;

   function automatic logic is_read(input logic ext, input logic [1:0] op);
      return ext ? op[1] : (op == 2'b10);
   endfunction

   function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_req_t r);
      logic                 rd;
      logic [1:0]           st;
      logic [1:0]           ta;
      logic [DATA_BITS-1:0] dat;
      rd  = is_read(r.ext, r.op);
      st  = r.ext ? 2'b00 : 2'b01;
      ta  = rd ? 2'b11 : 2'b10;
      dat = rd ? {DATA_BITS{1'b1}} : r.wdata;
      return {{PRE_BITS{1'b1}}, st, r.op, r.phy, r.rad, ta, dat};
   endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int DIV_W    = 8,
   parameter int HALF_DIV = 4,
   parameter int CLK_HZ   = 20_000_000,
   parameter int MAX_HZ   = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic fall_evt
);
   localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 1 || HALF_DIV > (1 << DIV_W) - 1) begin : g_bad_div
         $error("mdio_clkdiv: HALF_DIV out of range for DIV_W");
      end
      if (CLK_HZ > 2 * HALF_DIV * MAX_HZ) begin : g_too_fast
         $error("mdio_clkdiv: management clock would exceed its maximum rate");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign fall_evt = run & mdc & (cnt == LAST);

   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  mgmt_req_t            req,
   input  logic                 fall_evt,
   input  logic                 mdio_in,
   output logic                 busy,
   output logic                 done,
   output logic                 mdio_out,
   output logic                 mdio_oe,
   output logic [DATA_BITS-1:0] rdata,
   output logic                 no_resp
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] frame_q;
   logic                  rd_q;
   logic [IDX_W-1:0]      bitidx;
   logic [DATA_BITS-1:0]  cap;
   logic [DATA_BITS-1:0]  cap_nxt;

   assign cap_nxt  = {cap[DATA_BITS-2:0], mdio_in};
   assign mdio_out = busy ? frame_q[FRAME_BITS-1] : 1'b1;
   assign mdio_oe  = busy & ~(rd_q & (bitidx >= IDX_W'(TA_START)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         frame_q <= '0;
         rd_q    <= 1'b0;
         bitidx  <= '0;
         cap     <= '0;
         rdata   <= '0;
         no_resp <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               busy    <= 1'b1;
               frame_q <= build_frame(req);
               rd_q    <= is_read(req.ext, req.op);
               bitidx  <= '0;
            end
         end else if (fall_evt) begin
            if (rd_q && bitidx >= IDX_W'(DATA_START)) cap <= cap_nxt;
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
            if (bitidx == LAST_IDX) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               no_resp <= rd_q & (&cap_nxt);
               if (rd_q) rdata <= cap_nxt;
            end else begin
               bitidx <= bitidx + 1'b1;
            end
         end
      end
   end

   a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rd_q && $fell(mdio_oe) |-> bitidx == IDX_W'(TA_START));
   a_r10_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(no_resp));
   a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rdata));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int HALF_DIV = 4,
   parameter int CLK_HZ   = 20_000_000,
   parameter int MAX_HZ   = 2_500_000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_ext,
   input  logic [1:0]  req_op,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rdata,
   output logic        no_resp,
   output logic        mdc,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic        mdio_in
);
   mgmt_req_t req;
   logic      fall_evt;

   assign req = '{ext: req_ext, op: req_op, phy: req_phy, rad: req_reg, wdata: req_wdata};

   mdio_clkdiv #(
      .DIV_W(DIV_W), .HALF_DIV(HALF_DIV), .CLK_HZ(CLK_HZ), .MAX_HZ(MAX_HZ)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc), .fall_evt(fall_evt)
   );

   mdio_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
      .fall_evt(fall_evt), .mdio_in(mdio_in), .busy(busy), .done(done),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rdata(rdata), .no_resp(no_resp)
   );

   a_r11_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);
   a_r7_mdc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !$past(busy) |-> !mdc);
   a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> $stable(mdio_out) && $stable(mdio_oe));
   a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $fell(mdio_oe) |-> $fell(mdc));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
   localparam int CLK_P = 10;
   localparam int HALF  = 4;
   localparam int BITP  = 2 * HALF;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ext = 0;
   logic [1:0] req_op = 0;
   logic [4:0] req_phy = 0, req_reg = 0;
   logic [15:0] req_wdata = 0;
   logic busy, done, no_resp, mdc, mdio_out, mdio_oe;
   logic [15:0] rdata;
   logic mdio_in = 1;

   int n_checks = 0, n_err = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   mdio_master #(.HALF_DIV(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ext(req_ext),
      .req_op(req_op), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .no_resp(no_resp), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   // reference model state
   bit m_busy, m_done, m_read, m_nr;
   int m_t, b, b2;
   logic [15:0] m_rd, m_cap;
   bit m_q[$];
   bit phy_on = 1;
   logic [15:0] phy_resp = 16'h0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_read = 0; m_nr = 0; m_t = 0;
         m_rd = 0; m_cap = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (m_t % BITP == BITP - 1) begin
               b = m_t / BITP;
               if (m_read && b >= 48) m_cap = {m_cap[14:0], mdio_in};
               if (b == 63) begin
                  m_busy = 0; m_done = 1;
                  m_nr = m_read && (m_cap == 16'hFFFF);
                  if (m_read) m_rd = m_cap;
               end
            end
            m_t++;
         end else if (req_valid) begin
            m_read = req_ext ? req_op[1] : (req_op == 2'b10);
            m_q.delete();
            for (int i = 0; i < 32; i++) m_q.push_back(1);
            m_q.push_back(0);
            m_q.push_back(!req_ext);
            for (int i = 1; i >= 0; i--) m_q.push_back(req_op[i]);
            for (int i = 4; i >= 0; i--) m_q.push_back(req_phy[i]);
            for (int i = 4; i >= 0; i--) m_q.push_back(req_reg[i]);
            m_q.push_back(1);
            m_q.push_back(m_read);
            for (int i = 15; i >= 0; i--) m_q.push_back(m_read ? 1'b1 : req_wdata[i]);
            m_busy = 1; m_t = 0;
         end
      end
   end

   // PHY answer, updated away from the active edge
   always @(negedge clk) begin
      mdio_in <= 1'b1;
      if (m_busy && m_read && phy_on) begin
         b2 = m_t / BITP;
         if (b2 >= 48) mdio_in <= phy_resp[63 - b2];
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 busy", busy, m_busy);
         chk("R8 done", done, m_done);
         chk("R6 rdata", rdata, m_rd);
         chk("R10 no_resp", no_resp, m_nr);
         if (m_busy) begin
            chk("R7 mdc", mdc, (m_t % BITP) >= HALF);
            chk("R5 oe", mdio_oe, !(m_read && (m_t / BITP) >= 46));
            if (!(m_read && (m_t / BITP) >= 46))
               chk("R2 out", mdio_out, m_q[m_t / BITP]);
         end else begin
            chk("R7 mdc idle", mdc, 1'b0);
            chk("R11 oe idle", mdio_oe, 1'b0);
         end
      end
   end

   task automatic run_frame(input bit ext, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] wd,
                            input bit present, input logic [15:0] resp);
      @(negedge clk);
      phy_on = present; phy_resp = resp;
      req_ext = ext; req_op = op; req_phy = phy; req_reg = rg; req_wdata = wd;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      do @(negedge clk); while (!done);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 mdc", mdc, 0);
      chk("R1 oe", mdio_oe, 0); chk("R1 rdata", rdata, 0); chk("R1 no_resp", no_resp, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R4 short write, with R9 ignored request in the middle
      fork
         run_frame(0, 2'b01, 5'h13, 5'h0A, 16'hA55A, 1, 16'h0);
         begin
            repeat (100) @(negedge clk);
            req_valid = 1; req_op = 2'b10; req_phy = 5'h1F; // R9: must be ignored
            @(negedge clk);
            req_valid = 0;
         end
      join
      chk("R9 no extra frame", busy, 0);

      // R3/R5/R6 short read
      run_frame(0, 2'b10, 5'h01, 5'h02, 16'h0, 1, 16'hC3A5);
      chk("R6 short read", rdata, 16'hC3A5);
      chk("R10 answered", no_resp, 0);

      // R3 extended address and write
      run_frame(1, 2'b00, 5'h04, 5'h03, 16'h8001, 1, 16'h0);
      run_frame(1, 2'b01, 5'h04, 5'h03, 16'h1234, 1, 16'h0);
      chk("R6 rdata held over writes", rdata, 16'hC3A5);

      // R3 extended read
      run_frame(1, 2'b11, 5'h1C, 5'h1E, 16'h0, 1, 16'h0F0F);
      chk("R6 ext read", rdata, 16'h0F0F);

      // R10 extended read-increment, no PHY present
      run_frame(1, 2'b10, 5'h07, 5'h01, 16'h0, 0, 16'h0);
      chk("R10 no response", no_resp, 1);
      chk("R10 rdata ones", rdata, 16'hFFFF);

      // R10 flag cleared by a following write
      run_frame(0, 2'b01, 5'h00, 5'h1F, 16'h0000, 1, 16'h0);
      chk("R10 cleared", no_resp, 0);

      // R6 read of 0x0001 boundary pattern
      run_frame(0, 2'b10, 5'h15, 5'h11, 16'h0, 1, 16'h0001);
      chk("R6 lsb only", rdata, 16'h0001);

      repeat (5) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end
endmodule